// File: doc/BRIEF.md
# Edge-Set Interrupt Event Register

This block holds a 32-bit interrupt event register and a matching 32-bit interrupt mask register behind a simple memory-mapped register bus. Event bits are raised in two ways: a rising edge on the hardware source for that bit, or software writing ones to the event-set address. Once raised, an event bit stays high until software writes a one to the same bit position at the event-clear address. The block drives one interrupt line. That line is high whenever any event bit is high and its mask bit is also high.

Some events carry special rules. The software interrupt has no hardware source. The late-acknowledge event takes its three hardware sources only while an enable input is high. The cycle-overrun event is seen only while the cycle-master input is high, and when it is seen the block sends a one-cycle clear request back to that control. While the fatal-error event is set, hardware cannot set the event bits of the affected context; software can still set them.

Register reads are combinational on `bus_rdata`. Writes take effect on the clock edge at which `bus_wr` is high. An asynchronous active-low reset clears all state. The release of that reset is synchronised inside the block.

Top module: `irq_event_reg`

## Requirements
- R1: A write to address 80h sets every event bit whose write-data bit is 1. Bits written with 0 keep their value.
- R2: Event bits never clear on their own. A bit clears only when a write to address 84h has a 1 in that position, and write-data bits of 0 leave their event bits unchanged.
- R3: A hardware source sets its event bit on a 0-to-1 transition. The bit is set at the first clock edge that samples the source high after a low sample. A source that stays high does not set the bit again after it has been cleared.
- R4: Reading 80h returns the raw event register. Reading 84h returns the event register ANDed bit by bit with the mask register. Reading 88h or 8Ch returns the mask register. Any other address reads 0.
- R5: Bits 31, 30, 28 and 14 down to 10 always read 0 at every address, in both the event and the mask register. Writes and hardware sources do not change them.
- R6: Bit 29 (software interrupt) is set only by a write to 80h. Input `hw_src[29]` has no effect.
- R7: Bit 27 (late acknowledge) is set by a rising edge on any bit of `ack_src`, but only while `ack_tardy_en` is 1. Input `hw_src[27]` has no effect.
- R8: Bit 25 (cycle overrun) is set by a rising edge of `hw_src[25]` only while `cycle_master` is 1. In the same clock edge that sets bit 25, `cyc_master_clr` goes high for exactly one cycle.
- R9: While bit 24 (fatal error) is 1, hardware edges on the context bits selected by `CTX_MASK` (bits 7 down to 0 by default) do not set those bits. Writes to 80h still set them, and other bits keep setting from hardware.
- R10: The mask register is set by writing ones to 88h and cleared by writing ones to 8Ch. Bits written with 0 keep their value.
- R11: `irq` is 1 exactly when some bit is 1 in both the event register and the mask register.
- R12: If a hardware edge and a write of 1 to 84h hit the same bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| hw_src | input | 32 | Per-bit hardware event sources, edge sensitive |
| ack_src | input | ACK_N | Late-acknowledge sources: receive data pending, response unit busy, late acknowledge sent |
| ack_tardy_en | input | 1 | Enable for the late-acknowledge event |
| cycle_master | input | 1 | Cycle-master control state |
| cyc_master_clr | output | 1 | One-cycle request to clear the cycle-master control |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench holds a source high after its event has been cleared. A design that sets on the level instead of the edge would set the bit again at once. It drives a hardware edge and a clear write to the same bit in the same cycle. A design that gives priority to the clear would lose that event. It toggles the sources of the gated events while their enables are low, and the bits of a blocked context while the fatal-error bit is set. A design that ignores these gates would show bits that should stay 0. It also reads the clear address with a partial mask, writes all-ones to reach the reserved bits, and times the one-cycle cycle-master clear pulse. A mistake in any of these would show up as wrong read data or a pulse that is missing or too long.

// File: rtl/irq_ev_pkg.sv
package irq_ev_pkg;
  localparam int REG_W = 32;

  localparam int A_EV_SET = 'h80;
  localparam int A_EV_CLR = 'h84;
  localparam int A_MK_SET = 'h88;
  localparam int A_MK_CLR = 'h8C;

  localparam int B_SOFT    = 29;
  localparam int B_TARDY   = 27;
  localparam int B_CYCLONG = 25;
  localparam int B_FATAL   = 24;

  localparam logic [REG_W-1:0] RSVD_BITS  = 32'hD000_7C00;
  localparam logic [REG_W-1:0] VALID_BITS = ~RSVD_BITS;
  // bits whose hardware source maps straight through (soft and tardy excluded)
  localparam logic [REG_W-1:0] HW_DIRECT  =
    VALID_BITS & ~((REG_W'(1) << B_SOFT) | (REG_W'(1) << B_TARDY));

  typedef struct packed {
    logic [REG_W-1:0] set;
    logic [REG_W-1:0] clr;
  } w1_cmd_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  assign rise = src & ~prev_q;
endmodule

// File: rtl/irq_w1sc_bank.sv
module irq_w1sc_bank
  import irq_ev_pkg::*;
#(
  parameter int               W    = REG_W,
  parameter logic [W-1:0]     KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd_en;

  always_comb begin
    upd_en = |(set_vec | clr_vec);
    // set after clear: a concurrent set survives
    q_nxt  = ((q_r & ~clr_vec) | set_vec) & KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= '0;
    else if (upd_en) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/irq_event_reg.sv
module irq_event_reg
  import irq_ev_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               ACK_N    = 3,
  parameter logic [REG_W-1:0] CTX_MASK = 32'h0000_00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  hw_src,
  input  logic [ACK_N-1:0]  ack_src,
  input  logic              ack_tardy_en,
  input  logic              cycle_master,
  output logic              cyc_master_clr,
  output logic              irq
);
  localparam logic [REG_W-1:0] CTX_BLK = CTX_MASK & ~(REG_W'(1) << B_FATAL);

  logic             rst_ns;
  logic [REG_W-1:0] src_rise;
  logic [ACK_N-1:0] ack_rise;
  logic [REG_W-1:0] hw_set;
  logic             cyc_hit;
  logic             clr_req_q;
  w1_cmd_t          ev_cmd, mk_cmd;
  logic [REG_W-1:0] ev_q, mk_q;
  logic             hit_ev_set, hit_ev_clr, hit_mk_set, hit_mk_clr;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  irq_edge_detect #(.W(REG_W)) u_src_edge (
    .clk(clk), .rst_n(rst_ns), .src(hw_src), .rise(src_rise));

  irq_edge_detect #(.W(ACK_N)) u_ack_edge (
    .clk(clk), .rst_n(rst_ns), .src(ack_src), .rise(ack_rise));

  always_comb begin
    hit_ev_set = bus_wr && (bus_addr == ADDR_W'(A_EV_SET));
    hit_ev_clr = bus_wr && (bus_addr == ADDR_W'(A_EV_CLR));
    hit_mk_set = bus_wr && (bus_addr == ADDR_W'(A_MK_SET));
    hit_mk_clr = bus_wr && (bus_addr == ADDR_W'(A_MK_CLR));
  end

  // hardware set vector with per-event gating
  always_comb begin
    cyc_hit          = src_rise[B_CYCLONG] & cycle_master;
    hw_set           = src_rise & HW_DIRECT;
    hw_set[B_CYCLONG] = cyc_hit;
    hw_set[B_TARDY]  = ack_tardy_en & (|ack_rise);
    if (ev_q[B_FATAL]) hw_set = hw_set & ~CTX_BLK;
  end

  always_comb begin
    ev_cmd.set = hw_set | (hit_ev_set ? bus_wdata : '0);
    ev_cmd.clr = hit_ev_clr ? bus_wdata : '0;
    mk_cmd.set = hit_mk_set ? bus_wdata : '0;
    mk_cmd.clr = hit_mk_clr ? bus_wdata : '0;
  end

  irq_w1sc_bank #(.W(REG_W), .KEEP(VALID_BITS)) u_ev (
    .clk(clk), .rst_n(rst_ns), .set_vec(ev_cmd.set), .clr_vec(ev_cmd.clr), .q(ev_q));

  irq_w1sc_bank #(.W(REG_W), .KEEP(VALID_BITS)) u_mk (
    .clk(clk), .rst_n(rst_ns), .set_vec(mk_cmd.set), .clr_vec(mk_cmd.clr), .q(mk_q));

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) clr_req_q <= 1'b0;
    else         clr_req_q <= cyc_hit;
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(A_EV_SET): bus_rdata = ev_q;
      ADDR_W'(A_EV_CLR): bus_rdata = ev_q & mk_q;
      ADDR_W'(A_MK_SET),
      ADDR_W'(A_MK_CLR): bus_rdata = mk_q;
      default:           bus_rdata = '0;
    endcase
  end

  assign cyc_master_clr = clr_req_q;
  assign irq            = |(ev_q & mk_q);
endmodule

// File: rtl/irq_event_chk.sv
module irq_event_chk
  import irq_ev_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter logic [REG_W-1:0] CTX_MASK = 32'h0000_00FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic              ack_tardy_en,
  input logic              cycle_master,
  input logic              cyc_master_clr,
  input logic              irq,
  input logic [REG_W-1:0]  ev
);
  localparam logic [REG_W-1:0] CTX_BLK = CTX_MASK & ~(REG_W'(1) << B_FATAL);

  logic [REG_W-1:0] sw_set, sw_clr;
  always_comb begin
    sw_set = (bus_wr && bus_addr == ADDR_W'(A_EV_SET)) ? bus_wdata : '0;
    sw_clr = (bus_wr && bus_addr == ADDR_W'(A_EV_CLR)) ? bus_wdata : '0;
  end

  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & RSVD_BITS) == '0);

  assert_clear_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ev) & ~ev & ~$past(sw_clr)) == '0));

  assert_soft_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev[B_SOFT]) |-> $past(sw_set[B_SOFT]));

  assert_tardy_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ev[B_TARDY]) && !$past(sw_set[B_TARDY])) |-> $past(ack_tardy_en));

  assert_cyc_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_master_clr |-> ($past(cycle_master) && ev[B_CYCLONG]));

  assert_ctx_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev[B_FATAL]) |-> ((ev & ~$past(ev) & CTX_BLK & ~$past(sw_set)) == '0));

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(A_EV_CLR) && bus_rdata != '0) |-> irq);
endmodule

bind irq_event_reg irq_event_chk #(.ADDR_W(ADDR_W), .CTX_MASK(CTX_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack_tardy_en(ack_tardy_en),
  .cycle_master(cycle_master), .cyc_master_clr(cyc_master_clr), .irq(irq),
  .ev(ev_q));

// File: tb/tb_irq_event_reg.sv
module tb_irq_event_reg;
  localparam logic [31:0] VALID = 32'h2FFF_83FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] hw_src;
  logic [2:0]  ack_src;
  logic        ack_tardy_en;
  logic        cycle_master;
  logic        cyc_master_clr;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  irq_event_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_src(hw_src),
    .ack_src(ack_src), .ack_tardy_en(ack_tardy_en), .cycle_master(cycle_master),
    .cyc_master_clr(cyc_master_clr), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse_src(input int b);
    @(negedge clk); hw_src[b] = 1'b1;
    @(negedge clk); hw_src[b] = 1'b0;
  endtask

  task automatic pulse_ack(input int b);
    @(negedge clk); ack_src[b] = 1'b1;
    @(negedge clk); ack_src[b] = 1'b0;
  endtask

  task automatic wipe();
    wr(8'h84, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h80, d); chk("R4 reset event", d, 32'h0);
    rd(8'h88, d); chk("R10 reset mask", d, 32'h0);
    chk("R11 reset irq", {31'b0, irq}, 32'h0);
    chk("R8 reset clr pulse", {31'b0, cyc_master_clr}, 32'h0);
  endtask

  task automatic t_sw_set_clear();
    logic [31:0] d;
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R1/R5 set all", d, VALID);
    wr(8'h84, 32'hFFFF_FFFF);
    rd(8'h80, d); chk("R2 clear all", d, 32'h0);
    wr(8'h80, 32'h0000_0120);
    wr(8'h80, 32'h0);
    rd(8'h80, d); chk("R1 zero write no effect", d, 32'h0000_0120);
    wr(8'h84, 32'h0);
    repeat (3) @(negedge clk);
    rd(8'h80, d); chk("R2 holds, zero clear", d, 32'h0000_0120);
    wr(8'h84, 32'h0000_0100);
    rd(8'h80, d); chk("R2 partial clear", d, 32'h0000_0020);
    wipe();
  endtask

  task automatic t_mask_read();
    logic [31:0] d;
    wr(8'h88, 32'hFFFF_FFFF);
    rd(8'h8C, d); chk("R10/R5 mask set all", d, VALID);
    chk("R11 no event no irq", {31'b0, irq}, 32'h0);
    wr(8'h80, 32'h0001_0020);
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    wr(8'h8C, 32'h0000_0020);
    rd(8'h84, d); chk("R4 masked read", d, 32'h0001_0000);
    rd(8'h80, d); chk("R4 raw read", d, 32'h0001_0020);
    rd(8'h40, d); chk("R4 other address", d, 32'h0);
    wr(8'h8C, 32'h0001_0000);
    rd(8'h88, d); chk("R10 mask partial clear", d, VALID & ~32'h0001_0020);
    chk("R11 irq low when masked", {31'b0, irq}, 32'h0);
    wipe();
  endtask

  task automatic t_hw_edge();
    logic [31:0] d;
    @(negedge clk); hw_src[16] = 1'b1;
    @(negedge clk);
    rd(8'h80, d); chk("R3 edge sets", d, 32'h0001_0000);
    wr(8'h84, 32'h0001_0000);
    repeat (3) @(negedge clk);
    rd(8'h80, d); chk("R3 held level no reset", d, 32'h0);
    hw_src[16] = 1'b0;
    pulse_src(16);
    rd(8'h80, d); chk("R3 new edge sets", d, 32'h0001_0000);
    pulse_src(31); pulse_src(12);
    rd(8'h80, d); chk("R5 reserved hw ignored", d, 32'h0001_0000);
    wipe();
  endtask

  task automatic t_soft_tardy();
    logic [31:0] d;
    ack_tardy_en = 1'b1;
    pulse_src(29); pulse_src(27);
    rd(8'h80, d); chk("R6/R7 hw_src 29,27 ignored", d, 32'h0);
    ack_tardy_en = 1'b0;
    pulse_ack(1);
    rd(8'h80, d); chk("R7 gated off", d, 32'h0);
    ack_tardy_en = 1'b1;
    pulse_ack(2);
    rd(8'h80, d); chk("R7 ack edge sets", d, 32'h0800_0000);
    wr(8'h80, 32'h2000_0000);
    rd(8'h80, d); chk("R6 soft set", d, 32'h2800_0000);
    ack_tardy_en = 1'b0;
    wipe();
  endtask

  task automatic t_cycle();
    logic [31:0] d;
    cycle_master = 1'b0;
    pulse_src(25);
    rd(8'h80, d); chk("R8 ignored without master", d, 32'h0);
    chk("R8 no pulse", {31'b0, cyc_master_clr}, 32'h0);
    cycle_master = 1'b1;
    @(negedge clk); hw_src[25] = 1'b1;
    @(negedge clk);
    chk("R8 pulse high", {31'b0, cyc_master_clr}, 32'h1);
    rd(8'h80, d); chk("R8 event set", d, 32'h0200_0000);
    hw_src[25] = 1'b0;
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, cyc_master_clr}, 32'h0);
    cycle_master = 1'b0;
    wipe();
  endtask

  task automatic t_block();
    logic [31:0] d;
    wr(8'h80, 32'h0100_0000);
    pulse_src(2);
    rd(8'h80, d); chk("R9 ctx blocked", d, 32'h0100_0000);
    pulse_src(20);
    rd(8'h80, d); chk("R9 other bit passes", d, 32'h0110_0000);
    wr(8'h80, 32'h0000_0004);
    rd(8'h80, d); chk("R9 software still sets", d, 32'h0110_0004);
    wipe();
    pulse_src(2);
    rd(8'h80, d); chk("R9 unblocked after clear", d, 32'h0000_0004);
    wipe();
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(8'h80, 32'h0000_0018);
    @(negedge clk);
    bus_addr = 8'h84; bus_wdata = 32'h0000_0018; bus_wr = 1'b1; hw_src[3] = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; hw_src[3] = 1'b0;
    rd(8'h80, d); chk("R12 set beats clear", d, 32'h0000_0008);
    wipe();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    hw_src = '0; ack_src = '0; ack_tardy_en = 1'b0; cycle_master = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_sw_set_clear();
    t_mask_read();
    t_hw_edge();
    t_soft_tardy();
    t_cycle();
    t_block();
    t_race();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule